// File: doc/BRIEF.md
# Streaming Linear Classifier Scorer

This block turns a stream of fixed-point samples into class scores for a linear classifier. All input arrives on one 64-bit stream in a fixed order. The model comes first: one signed 32-bit bias per class, then a signed 8-bit weight matrix with one row per class. After the model comes a batch of samples, each a vector of unsigned 8-bit features. For every sample the block returns one signed 32-bit score per class. A score is the bias plus the sum of weight times feature over all features, and it wraps on overflow. The scores go out on a 64-bit output stream, in class order within a sample and in arrival order across samples.

A run begins with a start pulse. The batch length is taken from an input at that moment. The model is reloaded at the start of every run. While a sample's scores are waiting to leave, the input stream is held off. The final output beat of the batch is flagged with TLAST. After that beat the block either goes idle or, when auto-restart is set, begins the next run at once with no new start pulse.

Top module: `clf_stream_top`

## Requirements
- R1: During and after reset, and before any start, `sts_idle` is 1 and `s_axis_tready`, `m_axis_tvalid` and `sts_done` are 0.
- R2: A `ctl_start` pulse while idle captures `ctl_batch_len`, and `s_axis_tready` is 1 in the following cycle. The first NUM_CLASSES/2 accepted beats are biases: beat k holds class 2k in bits 31:0 and class 2k+1 in bits 63:32, each two's complement.
- R3: The next NUM_CLASSES*32 beats are weights. Beat number c*32+b carries class c, features 8b to 8b+7, with feature 8b+j in bits 8j+7:8j as a signed byte. Every later beat is a sample beat, 32 beats per sample, with feature 8b+j of beat b in bits 8j+7:8j as an unsigned byte.
- R4: Each class score equals bias plus the sum over features of signed weight times unsigned feature, taken modulo 2^32 as a signed 32-bit value.
- R5: Each sample yields NUM_CLASSES/2 output beats. Beat k carries class 2k in bits 31:0 and class 2k+1 in bits 63:32. Samples leave in arrival order, and `m_axis_tvalid` is 1 in the cycle after the last beat of a sample is accepted.
- R6: While any output beat of a sample is pending, `s_axis_tready` is 0. While `m_axis_tvalid` is 1 and `m_axis_tready` is 0, the output data and `m_axis_tlast` hold steady.
- R7: `m_axis_tlast` is 1 only on the last output beat of the last sample of a batch.
- R8: `sts_done` is a one-cycle pulse in the cycle after the final output beat is accepted. With `ctl_auto_restart` at 0 in that final cycle, the block returns to idle with `s_axis_tready` at 0.
- R9: With `ctl_auto_restart` at 1 in that final cycle, the block re-enters model loading at once: `sts_idle` stays 0 and `s_axis_tready` is 1 in the `sts_done` cycle. A new `ctl_batch_len` is captured at that point.
- R10: A `ctl_start` pulse while a run is in progress has no effect: results are unchanged, and no extra run follows the batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Start pulse, honoured only while idle |
| ctl_auto_restart | input | 1 | Begin the next run automatically at batch end |
| ctl_batch_len | input | BATCH_W | Samples per run, captured at run start (0 acts as 1) |
| s_axis_tdata | input | IN_W | Input stream data: biases, weights, then samples |
| s_axis_tvalid | input | 1 | Input stream valid |
| s_axis_tready | output | 1 | Input stream ready |
| m_axis_tdata | output | OUT_W | Two class scores per beat |
| m_axis_tvalid | output | 1 | Output stream valid |
| m_axis_tready | input | 1 | Output stream ready |
| m_axis_tlast | output | 1 | Final output beat of the batch |
| sts_done | output | 1 | One-cycle pulse at batch completion |
| sts_idle | output | 1 | Block is waiting for a start |

## Verification
The first score beat of a sample is due in the cycle after that sample's last input beat is taken, and the input is held off from that same cycle on. The bench therefore checks `m_axis_tvalid` and `s_axis_tready` at the falling edge right after its last feature handshake. `sts_done` is due one cycle after the final output handshake. It is checked at the very next falling edge after the bench has compared a beat flagged last, and at every other falling edge `sts_done` must be 0. The input stream is ready one cycle after a start or after an auto-restart. All handshakes are decided from values read at the falling edge, which stay stable until the next rising edge.

// File: rtl/clf_pkg.sv
package clf_pkg;

   localparam int SCORE_W   = 32;
   localparam int FEAT_BITS = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BIAS,
      ST_WGT,
      ST_SAMP,
      ST_DRAIN
   } clf_state_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/clf_ctrl.sv
module clf_ctrl
   import clf_pkg::*;
#(
   parameter int NUM_CLASSES = 10,
   parameter int FEAT_BEATS  = 32,
   parameter int BIAS_BEATS  = 5,
   parameter int BATCH_W     = 16,
   localparam int BB_W  = idx_w(BIAS_BEATS),
   localparam int CLS_W = idx_w(NUM_CLASSES),
   localparam int FB_W  = idx_w(FEAT_BEATS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               auto_restart,
   input  logic [BATCH_W-1:0] batch_len,
   input  logic               in_valid,
   input  logic               out_busy,
   input  logic               out_final_hs,
   output logic               in_ready,
   output logic               bias_acc,
   output logic [BB_W-1:0]    bias_beat,
   output logic               wgt_acc,
   output logic [CLS_W-1:0]   wcls,
   output logic [FB_W-1:0]    fbeat,
   output logic               samp_acc,
   output logic               samp_first,
   output logic               samp_end,
   output logic               batch_end,
   output logic               done,
   output logic               idle
);

   clf_state_e         state_q;
   logic [BATCH_W-1:0] len_q;
   logic [BATCH_W-1:0] samp_q;
   logic               accept;
   logic               fb_last;

   assign in_ready = (state_q == ST_BIAS) || (state_q == ST_WGT) ||
                     ((state_q == ST_SAMP) && !out_busy);
   assign accept     = in_valid && in_ready;
   assign bias_acc   = accept && (state_q == ST_BIAS);
   assign wgt_acc    = accept && (state_q == ST_WGT);
   assign samp_acc   = accept && (state_q == ST_SAMP);
   assign fb_last    = (fbeat == FB_W'(FEAT_BEATS - 1));
   assign samp_first = (fbeat == '0);
   assign samp_end   = fb_last;
   assign batch_end  = ({1'b0, samp_q} + (BATCH_W+1)'(1)) >= {1'b0, len_q};
   assign idle       = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         len_q     <= '0;
         samp_q    <= '0;
         bias_beat <= '0;
         wcls      <= '0;
         fbeat     <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q   <= ST_BIAS;
                  len_q     <= batch_len;
                  bias_beat <= '0;
                  wcls      <= '0;
                  fbeat     <= '0;
                  samp_q    <= '0;
               end
            end
            ST_BIAS: begin
               if (accept) begin
                  if (bias_beat == BB_W'(BIAS_BEATS - 1)) begin
                     bias_beat <= '0;
                     state_q   <= ST_WGT;
                  end else begin
                     bias_beat <= bias_beat + 1'b1;
                  end
               end
            end
            ST_WGT: begin
               if (accept) begin
                  if (fb_last) begin
                     fbeat <= '0;
                     if (wcls == CLS_W'(NUM_CLASSES - 1)) begin
                        wcls    <= '0;
                        samp_q  <= '0;
                        state_q <= ST_SAMP;
                     end else begin
                        wcls <= wcls + 1'b1;
                     end
                  end else begin
                     fbeat <= fbeat + 1'b1;
                  end
               end
            end
            ST_SAMP: begin
               if (accept) begin
                  if (fb_last) begin
                     fbeat <= '0;
                     if (batch_end) state_q <= ST_DRAIN;
                     else           samp_q  <= samp_q + 1'b1;
                  end else begin
                     fbeat <= fbeat + 1'b1;
                  end
               end
            end
            ST_DRAIN: begin
               if (out_final_hs) begin
                  done <= 1'b1;
                  if (auto_restart) begin
                     state_q   <= ST_BIAS;
                     len_q     <= batch_len;
                     bias_beat <= '0;
                     wcls      <= '0;
                     fbeat     <= '0;
                     samp_q    <= '0;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/clf_lane.sv
module clf_lane
   import clf_pkg::*;
#(
   parameter int FEAT_BEATS = 32,
   parameter int LANE_W     = 64,
   parameter int ADDR_W     = 5,
   localparam int NPROD  = LANE_W / FEAT_BITS,
   localparam int PROD_W = 2 * FEAT_BITS + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bias_we,
   input  logic [SCORE_W-1:0] bias_val,
   input  logic               wgt_we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [LANE_W-1:0]  beat_in,
   input  logic               mac_en,
   input  logic               first,
   output logic [SCORE_W-1:0] sum_next
);

   logic [LANE_W-1:0]  wmem [FEAT_BEATS];
   logic [SCORE_W-1:0] bias_q;
   logic [SCORE_W-1:0] acc_q;
   logic [SCORE_W-1:0] beat_sum;

   function automatic logic [SCORE_W-1:0] beat_dot(input logic [LANE_W-1:0] w,
                                                   input logic [LANE_W-1:0] f);
      logic [SCORE_W-1:0]       s;
      logic signed [PROD_W-1:0] p;
      s = '0;
      for (int j = 0; j < NPROD; j++) begin
         p = $signed(w[j*FEAT_BITS +: FEAT_BITS]) *
             $signed({1'b0, f[j*FEAT_BITS +: FEAT_BITS]});
         s = s + {{(SCORE_W-PROD_W){p[PROD_W-1]}}, p};
      end
      return s;
   endfunction

   assign beat_sum = beat_dot(wmem[addr], beat_in);
   assign sum_next = (first ? bias_q : acc_q) + beat_sum;

   always_ff @(posedge clk) begin
      if (wgt_we) wmem[addr] <= beat_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bias_q <= '0;
         acc_q  <= '0;
      end else begin
         if (bias_we) bias_q <= bias_val;
         if (mac_en)  acc_q  <= sum_next;
      end
   end

endmodule

// File: rtl/clf_out_pack.sv
module clf_out_pack
   import clf_pkg::*;
#(
   parameter int NUM_CLASSES = 10,
   parameter int OUT_W       = 64,
   localparam int TOT_W     = NUM_CLASSES * SCORE_W,
   localparam int OUT_BEATS = TOT_W / OUT_W,
   localparam int OB_W      = idx_w(OUT_BEATS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOT_W-1:0] scores,
   input  logic             load_last,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data,
   output logic             out_last,
   output logic             final_hs
);

   logic [TOT_W-1:0] sbuf_q;
   logic [OB_W-1:0]  idx_q;
   logic             valid_q;
   logic             blast_q;
   logic             hs;
   logic             at_end;

   assign hs        = valid_q && out_ready;
   assign at_end    = (idx_q == OB_W'(OUT_BEATS - 1));
   assign out_valid = valid_q;
   assign out_data  = sbuf_q[OUT_W-1:0];
   assign out_last  = valid_q && blast_q && at_end;
   assign final_hs  = hs && out_last;

   generate
      if (OUT_BEATS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sbuf_q  <= '0;
               idx_q   <= '0;
               valid_q <= 1'b0;
               blast_q <= 1'b0;
            end else if (load) begin
               sbuf_q  <= scores;
               idx_q   <= '0;
               valid_q <= 1'b1;
               blast_q <= load_last;
            end else if (hs) begin
               valid_q <= 1'b0;
            end
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sbuf_q  <= '0;
               idx_q   <= '0;
               valid_q <= 1'b0;
               blast_q <= 1'b0;
            end else if (load) begin
               sbuf_q  <= scores;
               idx_q   <= '0;
               valid_q <= 1'b1;
               blast_q <= load_last;
            end else if (hs) begin
               sbuf_q <= sbuf_q >> OUT_W;
               if (at_end) begin
                  valid_q <= 1'b0;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/clf_stream_top.sv
module clf_stream_top
   import clf_pkg::*;
#(
   parameter int NUM_CLASSES = 10,
   parameter int NUM_FEAT    = 256,
   parameter int IN_W        = 64,
   parameter int OUT_W       = 64,
   parameter int BATCH_W     = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_start,
   input  logic               ctl_auto_restart,
   input  logic [BATCH_W-1:0] ctl_batch_len,
   input  logic [IN_W-1:0]    s_axis_tdata,
   input  logic               s_axis_tvalid,
   output logic               s_axis_tready,
   output logic [OUT_W-1:0]   m_axis_tdata,
   output logic               m_axis_tvalid,
   input  logic               m_axis_tready,
   output logic               m_axis_tlast,
   output logic               sts_done,
   output logic               sts_idle
);

   localparam int FEAT_PER_BEAT = IN_W / FEAT_BITS;
   localparam int FEAT_BEATS    = NUM_FEAT / FEAT_PER_BEAT;
   localparam int BIAS_PER_BEAT = IN_W / SCORE_W;
   localparam int BIAS_BEATS    = NUM_CLASSES / BIAS_PER_BEAT;
   localparam int BB_W          = idx_w(BIAS_BEATS);
   localparam int CLS_W         = idx_w(NUM_CLASSES);
   localparam int FB_W          = idx_w(FEAT_BEATS);
   localparam int TOT_W         = NUM_CLASSES * SCORE_W;

   generate
      if (IN_W % SCORE_W != 0) begin : g_bad_in_w
         $error("IN_W must be a multiple of the score width");
      end
      if ((NUM_FEAT * FEAT_BITS) % IN_W != 0) begin : g_bad_feat
         $error("feature vector must fill whole input beats");
      end
      if (NUM_CLASSES % BIAS_PER_BEAT != 0) begin : g_bad_bias
         $error("biases must fill whole input beats");
      end
      if ((OUT_W % SCORE_W != 0) || (TOT_W % OUT_W != 0)) begin : g_bad_out_w
         $error("scores must fill whole output beats");
      end
   endgenerate

   logic              bias_acc;
   logic [BB_W-1:0]   bias_beat;
   logic              wgt_acc;
   logic [CLS_W-1:0]  wcls;
   logic [FB_W-1:0]   fbeat;
   logic              samp_acc;
   logic              samp_first;
   logic              samp_end;
   logic              batch_end;
   logic              final_hs;
   logic [TOT_W-1:0]  scores;

   clf_ctrl #(
      .NUM_CLASSES (NUM_CLASSES),
      .FEAT_BEATS  (FEAT_BEATS),
      .BIAS_BEATS  (BIAS_BEATS),
      .BATCH_W     (BATCH_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (ctl_start),
      .auto_restart (ctl_auto_restart),
      .batch_len    (ctl_batch_len),
      .in_valid     (s_axis_tvalid),
      .out_busy     (m_axis_tvalid),
      .out_final_hs (final_hs),
      .in_ready     (s_axis_tready),
      .bias_acc     (bias_acc),
      .bias_beat    (bias_beat),
      .wgt_acc      (wgt_acc),
      .wcls         (wcls),
      .fbeat        (fbeat),
      .samp_acc     (samp_acc),
      .samp_first   (samp_first),
      .samp_end     (samp_end),
      .batch_end    (batch_end),
      .done         (sts_done),
      .idle         (sts_idle)
   );

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_lane
      clf_lane #(
         .FEAT_BEATS (FEAT_BEATS),
         .LANE_W     (IN_W),
         .ADDR_W     (FB_W)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .bias_we  (bias_acc && (bias_beat == BB_W'(c / BIAS_PER_BEAT))),
         .bias_val (s_axis_tdata[(c % BIAS_PER_BEAT)*SCORE_W +: SCORE_W]),
         .wgt_we   (wgt_acc && (wcls == CLS_W'(c))),
         .addr     (fbeat),
         .beat_in  (s_axis_tdata),
         .mac_en   (samp_acc),
         .first    (samp_first),
         .sum_next (scores[c*SCORE_W +: SCORE_W])
      );
   end

   clf_out_pack #(
      .NUM_CLASSES (NUM_CLASSES),
      .OUT_W       (OUT_W)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (samp_acc && samp_end),
      .scores    (scores),
      .load_last (batch_end),
      .out_ready (m_axis_tready),
      .out_valid (m_axis_tvalid),
      .out_data  (m_axis_tdata),
      .out_last  (m_axis_tlast),
      .final_hs  (final_hs)
   );

endmodule

// File: rtl/clf_stream_chk.sv
module clf_stream_chk #(
   parameter int OUT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_auto_restart,
   input logic             s_axis_tready,
   input logic [OUT_W-1:0] m_axis_tdata,
   input logic             m_axis_tvalid,
   input logic             m_axis_tready,
   input logic             m_axis_tlast,
   input logic             sts_done,
   input logic             sts_idle
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      sts_idle |-> (!s_axis_tready && !m_axis_tvalid));

   assert_input_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      m_axis_tvalid |-> !s_axis_tready);

   assert_out_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_axis_tvalid && !m_axis_tready) |=>
         (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));

   assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      m_axis_tlast |-> m_axis_tvalid);

   assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sts_done |-> $past(m_axis_tvalid && m_axis_tready && m_axis_tlast));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sts_done |=> !sts_done);

   assert_restart_choice_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sts_done |-> (sts_idle != $past(ctl_auto_restart)));

endmodule

bind clf_stream_top clf_stream_chk #(.OUT_W(OUT_W)) chk_i (.*);

// File: tb/clf_stream_top_tb_top.sv
`timescale 1ns/1ps
module clf_stream_top_tb_top;

   localparam int NC = 10;
   localparam int NF = 256;
   localparam int W  = 64;
   localparam int FB = NF * 8 / W;
   localparam int NB = NC * 32 / W;
   localparam int MAXS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_start = 1'b0;
   logic        ctl_auto = 1'b0;
   logic [15:0] ctl_len = '0;
   logic [63:0] s_data = '0;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [63:0] m_data;
   logic        m_valid;
   logic        m_ready = 1'b0;
   logic        m_last;
   logic        done;
   logic        idle;

   always #2 clk = ~clk;

   clf_stream_top dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .ctl_start        (ctl_start),
      .ctl_auto_restart (ctl_auto),
      .ctl_batch_len    (ctl_len),
      .s_axis_tdata     (s_data),
      .s_axis_tvalid    (s_valid),
      .s_axis_tready    (s_ready),
      .m_axis_tdata     (m_data),
      .m_axis_tvalid    (m_valid),
      .m_axis_tready    (m_ready),
      .m_axis_tlast     (m_last),
      .sts_done         (done),
      .sts_idle         (idle)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   int          bs [NC];
   byte         wt [NC][NF];
   byte unsigned ft [MAXS][NF];
   logic [63:0] exp_q [$];
   bit          last_q [$];
   int          done_cnt = 0;
   bit          pend_done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] score(input int s, input int c);
      logic [31:0] a;
      a = bs[c];
      for (int f = 0; f < NF; f++) a = a + 32'(int'(wt[c][f]) * int'(ft[s][f]));
      return a;
   endfunction

   task automatic push_expected(input int n);
      for (int s = 0; s < n; s++)
         for (int k = 0; k < NB; k++) begin
            exp_q.push_back({score(s, 2*k+1), score(s, 2*k)});
            last_q.push_back((s == n-1) && (k == NB-1));
         end
   endtask

   task automatic rand_model();
      for (int c = 0; c < NC; c++) begin
         bs[c] = int'($urandom);
         for (int f = 0; f < NF; f++) wt[c][f] = byte'($urandom);
      end
      for (int s = 0; s < MAXS; s++)
         for (int f = 0; f < NF; f++) ft[s][f] = 8'($urandom);
   endtask

   task automatic send(input logic [63:0] d);
      if ($urandom_range(0, 7) == 0) @(negedge clk);
      s_data  = d;
      s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0;
   endtask

   task automatic send_model();
      logic [63:0] d;
      for (int k = 0; k < NB; k++) send({32'(bs[2*k+1]), 32'(bs[2*k])});
      for (int c = 0; c < NC; c++)
         for (int b = 0; b < FB; b++) begin
            for (int j = 0; j < 8; j++) d[8*j +: 8] = wt[c][8*b+j];
            send(d);
         end
   endtask

   task automatic send_sample(input int s);
      logic [63:0] d;
      for (int b = 0; b < FB; b++) begin
         for (int j = 0; j < 8; j++) d[8*j +: 8] = ft[s][8*b+j];
         send(d);
      end
      chk(m_valid === 1'b1, "R5", "scores one cycle after last feature", 64'(m_valid), 64'd1);
      chk(s_ready === 1'b0, "R6", "input held while scores pending", 64'(s_ready), 64'd0);
   endtask

   task automatic pulse_start();
      ctl_start = 1'b1;
      @(negedge clk);
      ctl_start = 1'b0;
   endtask

   always @(negedge clk) begin
      logic [63:0] e;
      bit          l;
      if (rst_n) begin
         if (pend_done) begin
            chk(done === 1'b1, "R8", "done pulse after final beat", 64'(done), 64'd1);
            pend_done = 1'b0;
            done_cnt++;
         end else if (done) begin
            chk(1'b0, "R8", "done without final beat", 64'd1, 64'd0);
         end
      end
      m_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (rst_n && m_valid && m_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5", "unexpected output beat", m_data, 64'd0);
         end else begin
            e = exp_q.pop_front();
            l = last_q.pop_front();
            chk(m_data === e, "R2 R3 R4 R5", "score beat", m_data, e);
            chk(m_last === l, "R7", "tlast flag", 64'(m_last), 64'(l));
            if (l) pend_done = 1'b1;
         end
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      chk(s_ready === 1'b0, "R1", "tready in reset", 64'(s_ready), 64'd0);
      chk(m_valid === 1'b0, "R1", "tvalid in reset", 64'(m_valid), 64'd0);
      chk(done === 1'b0,    "R1", "done in reset", 64'(done), 64'd0);
      chk(idle === 1'b1,    "R1", "idle in reset", 64'(idle), 64'd1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(idle === 1'b1 && s_ready === 1'b0, "R1", "idle before start",
          {62'd0, idle, s_ready}, 64'd2);

      fork
         begin : body
            // Run A: directed wrap and extreme rows, single batch
            rand_model();
            bs[0] = 32'h7FFF_FF00;
            bs[1] = -5;
            for (int f = 0; f < NF; f++) begin
               wt[0][f] = 8'sd127;
               wt[1][f] = -8'sd128;
               ft[0][f] = 8'd255;
               ft[1][f] = 8'd0;
               ft[2][f] = 8'd255;
            end
            ctl_len  = 16'd6;
            ctl_auto = 1'b0;
            push_expected(6);
            pulse_start();
            chk(s_ready === 1'b1 && idle === 1'b0, "R2", "loading after start",
                {62'd0, s_ready, idle}, 64'd2);
            send_model();
            for (int s = 0; s < 6; s++) begin
               send_sample(s);
               if (s == 2) pulse_start(); // R10: start while busy
            end
            wait (done_cnt == 1);
            chk(idle === 1'b1, "R8", "idle after batch", 64'(idle), 64'd1);
            chk(s_ready === 1'b0, "R8", "tready low after batch", 64'(s_ready), 64'd0);
            for (int i = 0; i < 4; i++) begin
               @(negedge clk);
               chk(idle === 1'b1 && s_ready === 1'b0, "R10", "no run from busy start",
                   {62'd0, idle, s_ready}, 64'd2);
            end

            // Run B: auto-restart into run C with a new length
            rand_model();
            ctl_len  = 16'd3;
            ctl_auto = 1'b1;
            push_expected(3);
            pulse_start();
            send_model();
            for (int s = 0; s < 3; s++) send_sample(s);
            ctl_len = 16'd2;
            wait (done_cnt == 2);
            chk(s_ready === 1'b1, "R9", "reloading without start", 64'(s_ready), 64'd1);
            chk(idle === 1'b0, "R9", "not idle on auto restart", 64'(idle), 64'd0);
            ctl_auto = 1'b0;
            @(negedge clk);

            // Run C: started by auto-restart, length 2
            rand_model();
            push_expected(2);
            send_model();
            for (int s = 0; s < 2; s++) send_sample(s);
            wait (done_cnt == 3);
            chk(idle === 1'b1, "R8", "idle after final run", 64'(idle), 64'd1);
            repeat (3) @(negedge clk);
            chk(exp_q.size() == 0, "R5", "all scores delivered",
                64'(exp_q.size()), 64'd0);
         end
         begin : watchdog
            repeat (100000) @(posedge clk);
            chk(1'b0, "R0", "watchdog expired", 64'd0, 64'd1);
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule